// File: doc/BRIEF.md
# Fault Isolation Register with Severity Decode

This block collects error events from surrounding hardware into a sticky fault register. Each bit is set by a one-cycle pulse on its own error line. The bit stays set until software clears it. Software reaches four registers through a small address/data port: the fault register, a per-bit mask, and two action registers. Reads are combinational and writes take effect on a single-cycle strobe.

For every fault bit that is set and not masked, the block joins the bit's action0 bit and action1 bit into a two-bit code. That code sorts the bit into one of four severity classes: unit checkstop, recoverable, host attention, or local-only. The block drives one level output for each of the first three classes. Alias addresses let software clear fault bits without a read-modify-write, and set or clear mask bits the same way. A hardware error that arrives in the same cycle as a software clear is never lost.

Top module: `fir_isolator`

## Requirements
- R1: A high level on error line i at a rising clock edge sets fault bit i at that edge. The register reads 1 in that bit afterwards.
- R2: A fault bit, once set, stays set until software writes the fault register at offset 0 or offset 1.
- R3: A write to offset 1 performs fault <= fault & wdata. A write to offset 0 replaces the fault register with wdata. All offsets are relative to the BASE parameter.
- R4: An error pulse that arrives in the same cycle as a write to offset 0 or offset 1 is ORed in after that write. The bit reads 1 afterwards.
- R5: Offset 3 writes the mask directly. Offset 4 performs mask <= mask & wdata. Offset 5 performs mask <= mask | wdata. A mask bit of 1 masks the fault bit.
- R6: Offset 6 holds the action0 register and offset 7 holds the action1 register. Both can be written and read back. A read of offset 1 returns the fault register, and a read of offset 4 or 5 returns the mask.
- R7: unitCheckstop is high exactly when some fault bit is set and unmasked and has action0=0, action1=0.
- R8: recoverable is high exactly when some fault bit is set and unmasked and has action0=0, action1=1.
- R9: hostAttn is high exactly when some fault bit is set and unmasked and has action0=1, action1=0.
- R10: A set bit with action0=1, action1=1 drives no output. A masked bit drives no output whatever its code.
- R11: After reset the fault register is 0, the mask is all ones, both action registers are 0, and all three outputs are low.
- R12: Offset 2 and every address outside BASE..BASE+7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| errIn | input | WIDTH | Error pulses, one line per fault bit |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for addr (combinational) |
| unitCheckstop | output | 1 | Some unmasked bit is in the checkstop class |
| recoverable | output | 1 | Some unmasked bit is in the recoverable class |
| hostAttn | output | 1 | Some unmasked bit is in the host-attention class |

## Verification
The assertions assume that the address and write strobe are stable across the sampling edge. They also assume that BASE+7 fits in the address width, so that offsets never wrap. The bench changes wrEn, addr, wdata and errIn only on falling edges, and it keeps every error pulse one cycle long. It reads results half a period after the updating edge. The near-exhaustive sweep uses an 8-bit configuration and drives every fault pattern against several mask patterns. It uses fixed action registers that put each of the four codes on two bits.

// File: rtl/fir_pkg.sv
package fir_pkg;

  localparam int unsigned OFS_FIR      = 0;
  localparam int unsigned OFS_FIR_AND  = 1;
  localparam int unsigned OFS_SPARE    = 2;
  localparam int unsigned OFS_MASK     = 3;
  localparam int unsigned OFS_MASK_AND = 4;
  localparam int unsigned OFS_MASK_OR  = 5;
  localparam int unsigned OFS_ACT0     = 6;
  localparam int unsigned OFS_ACT1     = 7;
  localparam int unsigned WINDOW       = 8;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_FIR  = 3'd1,
    RD_MASK = 3'd2,
    RD_ACT0 = 3'd3,
    RD_ACT1 = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   firWr;
    logic   firAnd;
    logic   maskWr;
    logic   maskAnd;
    logic   maskOr;
    logic   act0Wr;
    logic   act1Wr;
    rdSel_e rdSel;
  } firStrobe_t;

endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 'h40
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output firStrobe_t        stb
);

  localparam logic [ADDR_W-1:0] BaseA  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] WinA   = ADDR_W'(WINDOW);

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic [2:0]        slot;

  always_comb begin
    offset = addr - BaseA;
    hit    = (addr >= BaseA) && (offset < WinA);
    slot   = offset[2:0];
  end

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (hit) begin
      case (slot)
        3'(OFS_FIR): begin
          stb.firWr = wrEn;
          stb.rdSel = RD_FIR;
        end
        3'(OFS_FIR_AND): begin
          stb.firAnd = wrEn;
          stb.rdSel  = RD_FIR;
        end
        3'(OFS_MASK): begin
          stb.maskWr = wrEn;
          stb.rdSel  = RD_MASK;
        end
        3'(OFS_MASK_AND): begin
          stb.maskAnd = wrEn;
          stb.rdSel   = RD_MASK;
        end
        3'(OFS_MASK_OR): begin
          stb.maskOr = wrEn;
          stb.rdSel  = RD_MASK;
        end
        3'(OFS_ACT0): begin
          stb.act0Wr = wrEn;
          stb.rdSel  = RD_ACT0;
        end
        3'(OFS_ACT1): begin
          stb.act1Wr = wrEn;
          stb.rdSel  = RD_ACT1;
        end
        default: stb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  firStrobe_t       stb,
  input  logic [WIDTH-1:0] errIn,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] firQ,
  output logic [WIDTH-1:0] maskQ,
  output logic [WIDTH-1:0] act0Q,
  output logic [WIDTH-1:0] act1Q
);

  logic [WIDTH-1:0] firSw;
  logic [WIDTH-1:0] firNext;
  logic [WIDTH-1:0] maskNext;

  // Software update first, hardware errors ORed on top so none is lost.
  always_comb begin
    if (stb.firWr)       firSw = wdata;
    else if (stb.firAnd) firSw = firQ & wdata;
    else                 firSw = firQ;
    firNext = firSw | errIn;
  end

  always_comb begin
    if (stb.maskWr)       maskNext = wdata;
    else if (stb.maskAnd) maskNext = maskQ & wdata;
    else if (stb.maskOr)  maskNext = maskQ | wdata;
    else                  maskNext = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firQ  <= '0;
      maskQ <= '1;
      act0Q <= '0;
      act1Q <= '0;
    end else begin
      firQ  <= firNext;
      maskQ <= maskNext;
      if (stb.act0Wr) act0Q <= wdata;
      if (stb.act1Wr) act1Q <= wdata;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_FIR:  rdata = firQ;
      RD_MASK: rdata = maskQ;
      RD_ACT0: rdata = act0Q;
      RD_ACT1: rdata = act1Q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/fir_classify.sv
module fir_classify #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] firQ,
  input  logic [WIDTH-1:0] maskQ,
  input  logic [WIDTH-1:0] act0Q,
  input  logic [WIDTH-1:0] act1Q,
  output logic             unitCheckstop,
  output logic             recoverable,
  output logic             hostAttn
);

  logic [WIDTH-1:0] chkVec;
  logic [WIDTH-1:0] recVec;
  logic [WIDTH-1:0] hostVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic live;
    logic [1:0] code;
    always_comb begin
      live       = firQ[i] & ~maskQ[i];
      code       = {act0Q[i], act1Q[i]};
      chkVec[i]  = live && (code == 2'b00);
      recVec[i]  = live && (code == 2'b01);
      hostVec[i] = live && (code == 2'b10);
    end
  end

  always_comb begin
    unitCheckstop = |chkVec;
    recoverable   = |recVec;
    hostAttn      = |hostVec;
  end

endmodule

// File: rtl/fir_isolator.sv
module fir_isolator
  import fir_pkg::*;
#(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  errIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              unitCheckstop,
  output logic              recoverable,
  output logic              hostAttn
);

  firStrobe_t       stb;
  logic [WIDTH-1:0] fir;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] act0;
  logic [WIDTH-1:0] act1;

  fir_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  fir_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .errIn (errIn),
    .wdata (wdata),
    .rdata (rdata),
    .firQ  (fir),
    .maskQ (mask),
    .act0Q (act0),
    .act1Q (act1)
  );

  fir_classify #(.WIDTH(WIDTH)) u_cls (
    .firQ          (fir),
    .maskQ         (mask),
    .act0Q         (act0),
    .act1Q         (act1),
    .unitCheckstop (unitCheckstop),
    .recoverable   (recoverable),
    .hostAttn      (hostAttn)
  );

endmodule

// File: rtl/fir_isolator_chk.sv
module fir_isolator_chk #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 'h40
) (
  input logic              clk,
  input logic              rstN,
  input logic [WIDTH-1:0]  errIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic [WIDTH-1:0]  fir,
  input logic [WIDTH-1:0]  mask,
  input logic [WIDTH-1:0]  act0,
  input logic [WIDTH-1:0]  act1,
  input logic              unitCheckstop,
  input logic              recoverable,
  input logic              hostAttn
);

  localparam logic [ADDR_W-1:0] AFir    = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] AFirAnd = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] AMaskOr = ADDR_W'(BASE + 5);

  logic firTouched;
  assign firTouched = wrEn && (addr == AFir || addr == AFirAnd);

  // R1: every pulsed error line is reflected in the register afterwards
  p_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|errIn) |=> ((fir & $past(errIn)) == $past(errIn)));

  // R2: without a software write to the fault register no bit drops
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !firTouched |=> (($past(fir) & ~fir) == '0));

  // R4: a clear to zero in the same cycle as an error keeps that error
  p_clear_race_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AFirAnd && wdata == '0) |=> (fir == $past(errIn)));

  // R5: OR-alias leaves every written one set in the mask
  p_mask_or_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AMaskOr) |=> ((mask & $past(wdata)) == $past(wdata)));

  // R10: fully masked register keeps all outputs low
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '1) |-> !(unitCheckstop || recoverable || hostAttn));

  // R10: bits with the local-only code never raise a class output
  p_local_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((fir & ~mask & ~(act0 & act1)) == '0) |->
      !(unitCheckstop || recoverable || hostAttn));

  // R11: the first cycle out of reset starts masked and empty
  p_reset_state_r11: assert property (@(posedge clk)
    $rose(rstN) |-> (mask == '1 && fir == '0));

endmodule

bind fir_isolator fir_isolator_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .errIn         (errIn),
  .wrEn          (wrEn),
  .addr          (addr),
  .wdata         (wdata),
  .fir           (fir),
  .mask          (mask),
  .act0          (act0),
  .act1          (act1),
  .unitCheckstop (unitCheckstop),
  .recoverable   (recoverable),
  .hostAttn      (hostAttn)
);

// File: tb/tb_fir_isolator.sv
`timescale 1ns/1ps
module tb_fir_isolator;

  localparam int unsigned W  = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned B  = 'h40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  errIn = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          unitCheckstop, recoverable, hostAttn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fir_isolator #(.WIDTH(W), .ADDR_W(AW), .BASE(B)) dut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .unitCheckstop(unitCheckstop),
    .recoverable(recoverable), .hostAttn(hostAttn)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned ofs, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(ofs); wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [W-1:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  function automatic logic [2:0] expClass(input logic [W-1:0] f, input logic [W-1:0] m,
                                          input logic [W-1:0] a0, input logic [W-1:0] a1);
    logic [2:0] r = '0;
    for (int i = 0; i < W; i++) begin
      if (f[i] && !m[i]) begin
        if (!a0[i] && !a1[i]) r[2] = 1'b1;
        if (!a0[i] &&  a1[i]) r[1] = 1'b1;
        if ( a0[i] && !a1[i]) r[0] = 1'b1;
      end
    end
    return r;
  endfunction

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] maskSet [4];
    maskSet[0] = 8'h00; maskSet[1] = 8'h0F; maskSet[2] = 8'hA5; maskSet[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(B + 0, v); chk("R11 fir", v, 8'h00);
    rd(B + 3, v); chk("R11 mask", v, 8'hFF);
    rd(B + 6, v); chk("R11 act0", v, 8'h00);
    rd(B + 7, v); chk("R11 act1", v, 8'h00);
    chk("R11 outputs", {5'b0, unitCheckstop, recoverable, hostAttn}, 8'h00);

    // R6 action registers; codes per bit i%4: 00,01,10,11
    wr(B + 6, 8'hCC);
    wr(B + 7, 8'hAA);
    rd(B + 6, v); chk("R6 act0", v, 8'hCC);
    rd(B + 7, v); chk("R6 act1", v, 8'hAA);

    // R1 error pulse capture
    @(negedge clk); errIn = 8'h21;
    @(negedge clk); errIn = 8'h00;
    rd(B + 0, v); chk("R1 capture", v, 8'h21);
    rd(B + 1, v); chk("R6 fir alias read", v, 8'h21);
    // R2 stays set over idle cycles and unrelated writes
    repeat (5) @(negedge clk);
    wr(B + 3, 8'hF0);
    rd(B + 0, v); chk("R2 sticky", v, 8'h21);

    // R5 mask aliases
    wr(B + 5, 8'h03);
    rd(B + 3, v); chk("R5 mask or", v, 8'hF3);
    wr(B + 4, 8'h3C);
    rd(B + 4, v); chk("R5 mask and", v, 8'h30);
    rd(B + 5, v); chk("R6 mask alias read", v, 8'h30);

    // R3 fir AND alias and direct write
    wr(B + 0, 8'hFF);
    wr(B + 1, 8'h5A);
    rd(B + 0, v); chk("R3 and clear", v, 8'h5A);
    wr(B + 0, 8'h81);
    rd(B + 0, v); chk("R3 direct write", v, 8'h81);

    // R4 hardware set races software clear
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(B + 1); wdata = 8'h00; errIn = 8'h04;
    @(negedge clk);
    wrEn = 1'b0; errIn = 8'h00;
    rd(B + 0, v); chk("R4 race survives", v, 8'h04);

    // R12 unmapped offset and out-of-window addresses
    wr(B + 2, 8'h77);
    wr(B - 1, 8'h77);
    wr(B + 8, 8'h77);
    rd(B + 2, v); chk("R12 spare reads zero", v, 8'h00);
    rd(B - 1, v); chk("R12 below window", v, 8'h00);
    rd(B + 8, v); chk("R12 above window", v, 8'h00);
    rd(B + 0, v); chk("R12 fir untouched", v, 8'h04);
    rd(B + 3, v); chk("R12 mask untouched", v, 8'h30);

    // R7 R8 R9 R10 sweep: all fault patterns against several masks
    foreach (maskSet[mi]) begin
      wr(B + 3, maskSet[mi]);
      for (int f = 0; f < 256; f++) begin
        logic [2:0] e;
        wr(B + 0, W'(f));
        e = expClass(W'(f), maskSet[mi], 8'hCC, 8'hAA);
        chk("R7 checkstop", {7'b0, unitCheckstop}, {7'b0, e[2]});
        chk("R8 recoverable", {7'b0, recoverable}, {7'b0, e[1]});
        chk("R9 host attention", {7'b0, hostAttn}, {7'b0, e[0]});
      end
    end

    // R10 only local-only bits unmasked
    wr(B + 3, 8'h00);
    wr(B + 0, 8'h88);
    chk("R10 local only quiet", {5'b0, unitCheckstop, recoverable, hostAttn}, 8'h00);
    wr(B + 3, 8'hFF);
    wr(B + 0, 8'h77);
    chk("R10 masked quiet", {5'b0, unitCheckstop, recoverable, hostAttn}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule